// File: doc/BRIEF.md
# Core Regulator Power-Good and Reference Sequencer

This block orders the start-up of a core voltage regulator whose target is set by a 6-bit voltage-identification (VID) code, and it reports power-good. After enable, and once undervoltage lockout clears, the regulator reference is held on a fixed boot voltage. Incoming VID codes are ignored during this phase. When soft-start has finished and the core has stayed inside its tolerance window for a set number of microseconds, the block moves the reference to the VID source and asserts an active-low power-good. A delayed power-good follows a fixed number of switching cycles later.

While running, any accepted change of the VID code or of the sleep request starts a blanking interval counted in switching cycles. During blanking, the active-low power-good is forced low and the delayed power-good is forced high, and a transition flag tells the protection logic that the target is moving. A strap sampled when enable rises chooses how sleep is handled. In one mode the VID source stays selected while sleep is requested. In the other mode a separate sleep voltage is selected.

Top module: `core_pg_seq`

## Requirements
- R1: While `en_i` is low or `uvlo_i` is high, `pg_n_o` is 1, `pg_dly_o` is 0, `xfer_o` is 0 and `ref_sel_o` is 2'b00, all in the same cycle. Dropping enable also restarts the whole sequence.
- R2: `ref_sel_o` encodes the reference source as follows: 2'b00 is the boot voltage, 2'b01 is the VID code and 2'b10 is the sleep voltage. Before the run phase, the output is 2'b00 whatever the VID input does.
- R3: The run phase starts only after `ss_done_i` and `core_ok_i` are both seen, followed by BOOT_US (10) `us_tick_i` pulses during which `core_ok_i` stays high. A cycle with `core_ok_i` low restarts that count.
- R4: In the run phase and outside blanking, `pg_n_o` is the inverse of `core_ok_i`.
- R5: `pg_dly_o` is high outside blanking only in the run phase, with `core_ok_i` high, after DLY_CYC (1007) `cyc_tick_i` pulses counted from run-phase entry.
- R6: In the run phase, a VID code passes a two-stage synchronizer. If it differs from the last accepted code, a blanking interval of BLANK_CYC (62) `cyc_tick_i` pulses starts three clock edges after the input change. During blanking, `pg_n_o` is 0 and `pg_dly_o` is 1.
- R7: A change of `slp_req_i`, synchronized the same way, starts the same blanking interval.
- R8: A new change that arrives while blanking is active reloads the full BLANK_CYC count.
- R9: `slp_strap_i` is captured on the rising edge of `en_i`. With the strap at 1, the run-phase reference stays 2'b01 during sleep. With the strap at 0, an accepted sleep request selects 2'b10.
- R10: A change of `slp_strap_i` after enable has risen has no effect on `ref_sel_o`.
- R11: VID changes before the run phase start no blanking, so `xfer_o` stays 0.
- R12: `xfer_o` is high exactly while blanking is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable, active high |
| uvlo_i | input | 1 | Supply undervoltage lockout active |
| ss_done_i | input | 1 | Soft-start ramp finished |
| core_ok_i | input | 1 | Core is within the tolerance window of its present target |
| vid_i | input | 6 | VID code, asynchronous |
| slp_req_i | input | 1 | Sleep request, asynchronous |
| slp_strap_i | input | 1 | Sleep mode strap: 1 keeps VID during sleep |
| cyc_tick_i | input | 1 | One-clock pulse per switching cycle |
| us_tick_i | input | 1 | One-clock pulse per microsecond |
| pg_n_o | output | 1 | Power-good, active low |
| pg_dly_o | output | 1 | Delayed power-good, active high |
| ref_sel_o | output | 2 | Reference source select |
| xfer_o | output | 1 | Transition in progress |

## Verification
The cases of interest are where two functions fall in the same cycle. The first is a VID change landing while blanking is still counting, where a reload must win over a decrement. The second is the delayed power-good terminal count expiring inside a blanking window. The bench provokes the first by issuing a second code change about forty switching cycles into a window. It provokes the second by changing the code shortly before the 1007th switching cycle. A behavioural model compares all four outputs on every clock. Spot checks confirm that blanking outlives its original end and that the delayed output stays high after the window closes.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_SOFT = 2'd1,
        PH_HOLD = 2'd2,
        PH_RUN  = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        REF_BOOT  = 2'b00,
        REF_VID   = 2'b01,
        REF_SLEEP = 2'b10
    } ref_e;
endpackage

// File: rtl/pgs_sync.sv
module pgs_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pgs_blank.sv
module pgs_blank #(
    parameter int LEN = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic start_i,
    input  logic tick_i,
    output logic active_o
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(LEN);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                        cnt_d = '0;
        else if (start_i)                 cnt_d = FULL;
        else if (tick_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/core_pg_seq.sv
module core_pg_seq
    import pgs_pkg::*;
#(
    parameter int VID_W     = 6,
    parameter int BOOT_US   = 10,
    parameter int DLY_CYC   = 1007,
    parameter int BLANK_CYC = 62,
    parameter int SYNC_N    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             uvlo_i,
    input  logic             ss_done_i,
    input  logic             core_ok_i,
    input  logic [VID_W-1:0] vid_i,
    input  logic             slp_req_i,
    input  logic             slp_strap_i,
    input  logic             cyc_tick_i,
    input  logic             us_tick_i,
    output logic             pg_n_o,
    output logic             pg_dly_o,
    output logic [1:0]       ref_sel_o,
    output logic             xfer_o
);
    localparam int BOOT_W = $clog2(BOOT_US + 1);
    localparam int DLY_W  = $clog2(DLY_CYC + 1);
    localparam logic [BOOT_W-1:0] BOOT_LAST = BOOT_W'(BOOT_US - 1);
    localparam logic [DLY_W-1:0]  DLY_END   = DLY_W'(DLY_CYC);

    typedef struct packed {
        phase_e             phase;
        logic               en_q;
        logic               strap;
        logic [VID_W-1:0]   vid_acc;
        logic               slp_acc;
        logic [BOOT_W-1:0]  boot_cnt;
        logic [DLY_W-1:0]   dly_cnt;
    } seq_t;

    seq_t st_d, st_q;

    logic [VID_W:0] sync_q;
    logic           blank_start, blank_clr, blank_on;
    logic           act, in_run, chg;

    pgs_sync #(.W(VID_W + 1), .STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({slp_req_i, vid_i}),
        .q_o   (sync_q)
    );

    pgs_blank #(.LEN(BLANK_CYC)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (blank_clr),
        .start_i  (blank_start),
        .tick_i   (cyc_tick_i),
        .active_o (blank_on)
    );

    always_comb begin
        st_d   = st_q;
        act    = en_i & ~uvlo_i;
        in_run = (st_q.phase == PH_RUN);
        chg    = (sync_q[VID_W-1:0] != st_q.vid_acc) || (sync_q[VID_W] != st_q.slp_acc);

        st_d.en_q    = en_i;
        if (en_i && !st_q.en_q) st_d.strap = slp_strap_i;
        st_d.vid_acc = sync_q[VID_W-1:0];
        st_d.slp_acc = sync_q[VID_W];

        blank_start = in_run && chg;
        blank_clr   = !act || !in_run;

        if (!act) begin
            st_d.phase    = PH_OFF;
            st_d.boot_cnt = '0;
            st_d.dly_cnt  = '0;
        end else begin
            unique case (st_q.phase)
                PH_OFF: st_d.phase = PH_SOFT;
                PH_SOFT: begin
                    if (ss_done_i && core_ok_i) begin
                        st_d.phase    = PH_HOLD;
                        st_d.boot_cnt = '0;
                    end
                end
                PH_HOLD: begin
                    if (!core_ok_i) begin
                        st_d.boot_cnt = '0;
                    end else if (us_tick_i) begin
                        if (st_q.boot_cnt == BOOT_LAST) begin
                            st_d.phase   = PH_RUN;
                            st_d.dly_cnt = '0;
                        end else begin
                            st_d.boot_cnt = st_q.boot_cnt + 1'b1;
                        end
                    end
                end
                PH_RUN: begin
                    if (cyc_tick_i && st_q.dly_cnt != DLY_END)
                        st_d.dly_cnt = st_q.dly_cnt + 1'b1;
                end
                default: st_d.phase = PH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic run_live, blank_live;
    assign run_live   = in_run && act;
    assign blank_live = blank_on && act;

    assign xfer_o   = blank_live;
    assign pg_n_o   = !(run_live && (blank_live || core_ok_i));
    assign pg_dly_o = run_live && (blank_live || ((st_q.dly_cnt == DLY_END) && core_ok_i));

    always_comb begin
        if (!run_live)                        ref_sel_o = REF_BOOT;
        else if (st_q.slp_acc && !st_q.strap) ref_sel_o = REF_SLEEP;
        else                                  ref_sel_o = REF_VID;
    end
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic       uvlo_i,
    input logic       cyc_tick_i,
    input logic       pg_n_o,
    input logic       pg_dly_o,
    input logic [1:0] ref_sel_o,
    input logic       xfer_o
);
    logic act;
    assign act = en_i && !uvlo_i;

    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (pg_n_o && !pg_dly_o && !xfer_o && ref_sel_o == 2'b00));

    a_r6_blank_forces: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |-> (!pg_n_o && pg_dly_o));

    a_r11_no_blank_in_boot: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_sel_o == 2'b00) |-> !xfer_o);

    a_r12_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $fell(xfer_o)) |-> $past(cyc_tick_i));

    a_r5_dly_implies_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (pg_dly_o && !xfer_o) |-> !pg_n_o);

    a_r2_ref_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ref_sel_o != 2'b11);
endmodule

bind core_pg_seq pgs_checker u_pgs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .uvlo_i     (uvlo_i),
    .cyc_tick_i (cyc_tick_i),
    .pg_n_o     (pg_n_o),
    .pg_dly_o   (pg_dly_o),
    .ref_sel_o  (ref_sel_o),
    .xfer_o     (xfer_o)
);

// File: tb/core_pg_seq_tb.sv
`timescale 1ns/1ps
module core_pg_seq_tb;
    logic clk = 0;
    logic rst_n = 0;
    logic en = 0, uvlo = 0, ss_done = 0, core_ok = 0;
    logic [5:0] vid = 0;
    logic slp = 0, strap = 0, cyc_tick = 0, us_tick = 0;
    logic pg_n, pg_dly, xfer;
    logic [1:0] ref_sel;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    core_pg_seq u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_i(uvlo), .ss_done_i(ss_done),
        .core_ok_i(core_ok), .vid_i(vid), .slp_req_i(slp), .slp_strap_i(strap),
        .cyc_tick_i(cyc_tick), .us_tick_i(us_tick),
        .pg_n_o(pg_n), .pg_dly_o(pg_dly), .ref_sel_o(ref_sel), .xfer_o(xfer)
    );

    // behavioural reference model
    int m_ph = 0;
    int m_hold = 0;
    int m_dly = 0;
    int m_blank = 0;
    bit m_strap = 0;
    bit m_en_prev = 0;
    logic [6:0] hist[$] = '{7'd0, 7'd0, 7'd0, 7'd0};

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_hold = 0; m_dly = 0; m_blank = 0; m_strap = 0; m_en_prev = 0;
            hist = '{7'd0, 7'd0, 7'd0, 7'd0};
        end else begin
            bit a, ev, was_run;
            a = en && !uvlo;
            was_run = (m_ph == 3);
            ev = (hist[2] != hist[1]);
            if (en && !m_en_prev) m_strap = strap;
            m_en_prev = en;
            if (!a || !was_run) m_blank = 0;
            else if (ev) m_blank = 62;
            else if (cyc_tick && m_blank > 0) m_blank = m_blank - 1;
            if (!a) begin
                m_ph = 0; m_hold = 0; m_dly = 0;
            end else if (m_ph == 0) m_ph = 1;
            else if (m_ph == 1) begin
                if (ss_done && core_ok) begin m_ph = 2; m_hold = 0; end
            end else if (m_ph == 2) begin
                if (!core_ok) m_hold = 0;
                else if (us_tick) begin
                    if (m_hold == 9) begin m_ph = 3; m_dly = 0; end
                    else m_hold = m_hold + 1;
                end
            end else if (cyc_tick && m_dly < 1007) m_dly = m_dly + 1;
            hist.push_back({slp, vid});
            void'(hist.pop_front());
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act_v, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit a, run, bl;
            int e_ref;
            a = en && !uvlo;
            run = (m_ph == 3) && a;
            bl = (m_blank > 0) && a;
            e_ref = !run ? 0 : ((hist[1][6] && !m_strap) ? 2 : 1);
            chk(xfer == bl, tag, "xfer", xfer, bl);
            chk(pg_n == !(run && (bl || core_ok)), tag, "pg_n", pg_n, !(run && (bl || core_ok)));
            chk(pg_dly == (run && (bl || (m_dly == 1007 && core_ok))), tag, "pg_dly", pg_dly,
                run && (bl || (m_dly == 1007 && core_ok)));
            chk(ref_sel == e_ref, tag, "ref_sel", ref_sel, e_ref);
        end
    end

    // tick generators
    initial begin
        int c = 0;
        forever begin
            @(posedge clk); #2;
            c++;
            cyc_tick = (c % 3 == 0);
            us_tick = (c % 5 == 0);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic spot(input string req, input string what, input int act_v, input int exp_v);
        @(negedge clk);
        chk(act_v == exp_v, req, what, act_v, exp_v);
    endtask

    task automatic wait_run(input string req);
        int k = 0;
        while (pg_n && k < 400) begin @(negedge clk); k++; end
        chk(!pg_n, req, "pg_n reached run", pg_n, 0);
        cyc(1);
    endtask

    task automatic finish_up();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_up();
    end

    initial begin
        cyc(3);
        rst_n = 1;
        cyc(2);
        @(negedge clk);
        chk(pg_n == 1, "R1", "reset pg_n", pg_n, 1);
        chk(pg_dly == 0, "R1", "reset pg_dly", pg_dly, 0);
        chk(xfer == 0, "R1", "reset xfer", xfer, 0);
        chk(ref_sel == 0, "R2", "reset ref", ref_sel, 0);

        // boot phase, strap high
        tag = "R2"; cyc(1);
        strap = 1; en = 1; core_ok = 1;
        cyc(6); vid = 6'h15; cyc(8); vid = 6'h2a;
        cyc(6);
        @(negedge clk);
        chk(xfer == 0, "R11", "boot vid change xfer", xfer, 0);
        chk(ref_sel == 0, "R2", "boot ref", ref_sel, 0);
        tag = "R3"; cyc(1);
        ss_done = 1;
        cyc(30); core_ok = 0; cyc(1); core_ok = 1;
        cyc(30);
        spot("R3", "hold restarted pg_n", pg_n, 1);
        cyc(1);
        wait_run("R3");
        spot("R9", "strap high ref vid", ref_sel, 1);

        // strap change ignored, sleep change blanks
        tag = "R7"; cyc(1);
        strap = 0; slp = 1;
        cyc(5);
        spot("R7", "sleep change xfer", xfer, 1);
        spot("R10", "strap ignored ref", ref_sel, 1);
        tag = "R6"; cyc(1);
        core_ok = 0; cyc(3);
        spot("R6", "forced pg_n", pg_n, 0);
        spot("R6", "forced pg_dly", pg_dly, 1);
        cyc(1); core_ok = 1;
        cyc(200);
        spot("R12", "blank ended", xfer, 0);
        tag = "R4"; cyc(1);
        core_ok = 0; cyc(2);
        spot("R4", "out of window pg_n", pg_n, 1);
        cyc(1); core_ok = 1;

        // blanking across delayed power-good terminal count
        tag = "R5"; cyc(2700);
        vid = 6'h0f;
        cyc(300);
        spot("R5", "pg_dly after count", pg_dly, 1);
        spot("R12", "blank done", xfer, 0);

        // restart of blanking
        tag = "R8"; cyc(1);
        vid = 6'h10; cyc(120); vid = 6'h11; cyc(120);
        spot("R8", "restarted blank alive", xfer, 1);
        cyc(100);
        spot("R8", "restarted blank over", xfer, 0);

        // disable, re-enable with strap low
        tag = "R1"; cyc(1);
        en = 0; #1;
        spot("R1", "disabled pg_dly", pg_dly, 0);
        spot("R1", "disabled pg_n", pg_n, 1);
        cyc(5);
        tag = "R9"; strap = 0; slp = 0; en = 1;
        cyc(2); strap = 1;
        wait_run("R9");
        cyc(200);
        slp = 1; cyc(5);
        spot("R9", "sleep ref", ref_sel, 2);
        cyc(200);
        tag = "R1"; uvlo = 1; #1;
        spot("R1", "uvlo pg_n", pg_n, 1);
        spot("R1", "uvlo ref", ref_sel, 0);
        cyc(5);
        finish_up();
    end
endmodule